// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block keeps a bank of transmit mailboxes for a CAN controller. It decides which pending frame goes next to the bit-level protocol engine. Each mailbox holds a mode, a 4-bit priority, an identifier in standard or extended form, a DLC, a remote-request flag and eight data bytes. Software-style writes load all of these through one word-wide write port. The port carries a mailbox index, a word selector and a 32-bit value. Writing the control word with its transfer bit set arms a mailbox.

A two-state sequencer picks one mailbox only while the engine is idle. It presents that frame on the engine request bus and holds it until the engine returns a done, lost-arbitration or error pulse. A successful frame sets the mailbox's ready flag. A lost or failed frame leaves the mailbox pending for the next pick. A mailbox can be cancelled through an abort bitmask or through the abort bit of its control word. When the mailbox is on the wire at that moment, the cancel waits for the end of the frame. Every completion or cancellation produces a one-cycle event pulse for that mailbox.

Word selector codes on `wr_sel`: 0 mode word, 1 identifier word, 2 data bytes 0..3 (the low data word), 3 data bytes 4..7 (the high data word), 4 control word.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset every mailbox reports ready = 1 and aborted = 0, no event is pulsed, and no request is raised.
- R2: A control-word write with bit 23 set arms a mailbox whose mode (mode word bits 26:24) is 3 = transmit. The arm clears ready and aborted. Two clock edges after the write, eng_req rises carrying that mailbox's frame: DLC from control bits 19:16, remote flag from control bit 20, the high data word on eng_data[63:32] and the low data word on eng_data[31:0].
- R3: Among pending mailboxes the one with the numerically lowest priority (mode word bits 19:16, 0 most urgent, 15 least) is requested first.
- R4: Pending mailboxes of equal priority are requested in ascending index order.
- R5: While eng_req is high, eng_mb and the frame stay unchanged until a done, lost or error pulse. A mailbox armed meanwhile, even a more urgent one, waits for the next pick.
- R6: A done pulse during a request sets that mailbox's ready flag, removes it from the pending set and pulses its event output for one cycle.
- R7: A lost-arbitration or error pulse leaves the mailbox pending with ready = 0. The mailbox is requested again in a later pick.
- R8: An abort-port write cancels every pending mailbox whose mask bit is set and is not on the wire. Such a mailbox gets aborted = 1 and an event pulse and is never requested. Mask bits of idle mailboxes have no effect.
- R9: An abort aimed at the mailbox on the wire is deferred to the end of the frame. If the frame then ends with done, the mailbox ends ready = 1 and aborted = 0. If it ends with lost or error, the mailbox ends aborted = 1 with an event pulse and is not retried.
- R10: Identifier writes take effect only while the mailbox mode is 0 = disabled; otherwise they are dropped. In the identifier word, bit 29 selects extended format, bits 28:18 hold the 11-bit base and bits 17:0 hold the 18-bit extension.
- R11: A transfer command to a mailbox whose mode is not transmit is ignored. Ready stays 1 and no request follows.
- R12: Control bit 22 cancels the mailbox in the same way as its abort-port bit. When bits 22 and 23 are set together, the cancel wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mailbox word port |
| wr_mb | input | IW | Target mailbox index |
| wr_sel | input | 3 | Word selector (0 mode, 1 identifier, 2 low data, 3 high data, 4 control) |
| wr_data | input | 32 | Word value |
| abort_en | input | 1 | Abort strobe |
| abort_mask | input | NUM_MB | One bit per mailbox to cancel |
| eng_req | output | 1 | A frame is offered to the engine |
| eng_mb | output | IW | Index of the offered mailbox |
| eng_ide | output | 1 | Extended-format flag of the offered frame |
| eng_base | output | 11 | Base identifier |
| eng_xid | output | 18 | Identifier extension |
| eng_dlc | output | 4 | Data length code |
| eng_rtr | output | 1 | Remote-request flag |
| eng_data | output | 64 | Data bytes, high word in bits 63:32 |
| eng_done | input | 1 | Frame sent successfully (one-cycle pulse) |
| eng_lost | input | 1 | Arbitration lost (one-cycle pulse) |
| eng_err | input | 1 | Frame failed with a bus error (one-cycle pulse) |
| mb_ready | output | NUM_MB | Per-mailbox ready flag |
| mb_aborted | output | NUM_MB | Per-mailbox aborted flag |
| mb_event | output | NUM_MB | Per-mailbox completion or cancel pulse |

## Verification
The bench keeps a long frame on the wire and arms contenders with mixed priorities behind it. A design that re-arbitrated mid-frame would switch eng_mb early, and one that compared priorities in the wrong direction or broke ties by the highest index would emit the contenders in the wrong order. Lost and error endings are chained before a success. A design that dropped a failed mailbox would leave expected retries unmatched in the scoreboard. Aborts are aimed both at waiting mailboxes and at the one on the wire, with both frame endings. A design that cancelled the in-flight frame at once, or retried it after a deferred cancel, would show the wrong flags or an extra request. An identifier write while the mailbox transmits and an arm of a disabled mailbox are also checked. A design honouring either would send a changed identifier or raise a stray request.

// File: rtl/txmb_pkg.sv
package txmb_pkg;

  // word selector codes on the write port
  localparam logic [2:0] SEL_MODE  = 3'd0;
  localparam logic [2:0] SEL_IDENT = 3'd1;
  localparam logic [2:0] SEL_DLO   = 3'd2;
  localparam logic [2:0] SEL_DHI   = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;

  // mailbox mode codes
  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_TX  = 3'd3;

  localparam int PRIO_W = 4;

  typedef struct packed {
    logic        ide;
    logic [10:0] base;
    logic [17:0] xid;
    logic [3:0]  dlc;
    logic        rtr;
    logic [63:0] data;
  } frame_t;

  // mode word fields
  function automatic logic [2:0] mode_of(input logic [31:0] w);
    return w[26:24];
  endfunction

  function automatic logic [PRIO_W-1:0] prio_of(input logic [31:0] w);
    return w[19:16];
  endfunction

  // control word fields
  function automatic logic [3:0] dlc_of(input logic [31:0] w);
    return w[19:16];
  endfunction

  function automatic logic rtr_of(input logic [31:0] w);
    return w[20];
  endfunction

  function automatic logic cancel_of(input logic [31:0] w);
    return w[22];
  endfunction

  function automatic logic xfer_of(input logic [31:0] w);
    return w[23];
  endfunction

  // identifier word fields
  function automatic logic ide_of(input logic [31:0] w);
    return w[29];
  endfunction

  function automatic logic [10:0] base_of(input logic [31:0] w);
    return w[28:18];
  endfunction

  function automatic logic [17:0] xid_of(input logic [31:0] w);
    return w[17:0];
  endfunction

  // a candidate displaces the current best only when strictly more urgent
  function automatic logic more_urgent(input logic [PRIO_W-1:0] cand,
                                       input logic [PRIO_W-1:0] best);
    return cand < best;
  endfunction

endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
  import txmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              kill_port,
  input  logic              in_flight,
  input  logic              end_ok,
  input  logic              end_fail,
  output logic              eligible,
  output logic [PRIO_W-1:0] prio,
  output frame_t            frame,
  output logic              ready,
  output logic              aborted,
  output logic              event_o
);

  logic [2:0]        mode_q;
  logic [PRIO_W-1:0] prio_q;
  logic              ide_q;
  logic [10:0]       base_q;
  logic [17:0]       xid_q;
  logic [31:0]       dlo_q;
  logic [31:0]       dhi_q;
  logic [3:0]        dlc_q;
  logic              rtr_q;
  logic              pend_q;
  logic              ready_q;
  logic              abt_q;
  logic              abreq_q;
  logic              evt_q;

  // named decode events
  logic is_tx;
  logic ctrl_hit;
  logic arm_ok;
  logic kill;
  logic id_ok;

  assign is_tx    = (mode_q == MODE_TX);
  assign ctrl_hit = wr_hit && (wr_sel == SEL_CTRL);
  assign arm_ok   = ctrl_hit && xfer_of(wr_data) && is_tx && !pend_q;
  assign kill     = kill_port || (ctrl_hit && cancel_of(wr_data));
  assign id_ok    = wr_hit && (wr_sel == SEL_IDENT) && (mode_q == MODE_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      prio_q  <= '0;
      ide_q   <= 1'b0;
      base_q  <= '0;
      xid_q   <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      pend_q  <= 1'b0;
      ready_q <= 1'b1;
      abt_q   <= 1'b0;
      abreq_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (wr_hit && (wr_sel == SEL_MODE)) begin
        mode_q <= mode_of(wr_data);
        prio_q <= prio_of(wr_data);
      end
      if (id_ok) begin
        ide_q  <= ide_of(wr_data);
        base_q <= base_of(wr_data);
        xid_q  <= xid_of(wr_data);
      end
      if (wr_hit && (wr_sel == SEL_DLO)) dlo_q <= wr_data;
      if (wr_hit && (wr_sel == SEL_DHI)) dhi_q <= wr_data;

      if (end_ok) begin
        pend_q  <= 1'b0;
        ready_q <= 1'b1;
        abreq_q <= 1'b0;
        evt_q   <= 1'b1;
      end else if (end_fail) begin
        if (abreq_q || kill) begin
          pend_q  <= 1'b0;
          abt_q   <= 1'b1;
          abreq_q <= 1'b0;
          evt_q   <= 1'b1;
        end
      end else if (kill) begin
        if (in_flight) begin
          abreq_q <= 1'b1;
        end else if (pend_q) begin
          pend_q <= 1'b0;
          abt_q  <= 1'b1;
          evt_q  <= 1'b1;
        end
      end else if (arm_ok) begin
        pend_q  <= 1'b1;
        ready_q <= 1'b0;
        abt_q   <= 1'b0;
        dlc_q   <= dlc_of(wr_data);
        rtr_q   <= rtr_of(wr_data);
      end
    end
  end

  assign eligible   = pend_q && is_tx;
  assign prio       = prio_q;
  assign frame.ide  = ide_q;
  assign frame.base = base_q;
  assign frame.xid  = xid_q;
  assign frame.dlc  = dlc_q;
  assign frame.rtr  = rtr_q;
  assign frame.data = {dhi_q, dlo_q};
  assign ready      = ready_q;
  assign aborted    = abt_q;
  assign event_o    = evt_q;

endmodule

// File: rtl/txmb_select.sv
module txmb_select
  import txmb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]             eligible,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     found,
  output logic [IW-1:0]            idx
);

  logic [PRIO_W-1:0] best;

  // ascending scan with strict comparison keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (eligible[i] && (!found || more_urgent(prio[i], best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i];
      end
    end
  end

endmodule

// File: rtl/txmb_seq.sv
module txmb_seq #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          found,
  input  logic [IW-1:0] pick_idx,
  input  logic          eng_done,
  input  logic          eng_lost,
  input  logic          eng_err,
  output logic          busy,
  output logic [IW-1:0] cur_idx,
  output logic          launch,
  output logic          end_ok,
  output logic          end_fail
);

  logic frame_end;

  assign launch    = !busy && found;
  assign frame_end = busy && (eng_done || eng_lost || eng_err);
  assign end_ok    = busy && eng_done;
  assign end_fail  = busy && !eng_done && (eng_lost || eng_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_idx <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      cur_idx <= pick_idx;
    end else if (frame_end) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
  import txmb_pkg::*;
#(
  parameter  int NUM_MB = 8,
  localparam int IW     = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_mb,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              abort_en,
  input  logic [NUM_MB-1:0] abort_mask,
  output logic              eng_req,
  output logic [IW-1:0]     eng_mb,
  output logic              eng_ide,
  output logic [10:0]       eng_base,
  output logic [17:0]       eng_xid,
  output logic [3:0]        eng_dlc,
  output logic              eng_rtr,
  output logic [63:0]       eng_data,
  input  logic              eng_done,
  input  logic              eng_lost,
  input  logic              eng_err,
  output logic [NUM_MB-1:0] mb_ready,
  output logic [NUM_MB-1:0] mb_aborted,
  output logic [NUM_MB-1:0] mb_event
);

  logic [NUM_MB-1:0]             elig;
  logic [NUM_MB-1:0][PRIO_W-1:0] prio;
  frame_t                        frames [NUM_MB];
  logic                          found;
  logic [IW-1:0]                 pick_idx;
  logic                          busy;
  logic [IW-1:0]                 cur_idx;
  logic                          launch;
  logic                          end_ok;
  logic                          end_fail;
  frame_t                        cur_frame;

  txmb_select #(.N(NUM_MB), .IW(IW)) u_select (
    .eligible (elig),
    .prio     (prio),
    .found    (found),
    .idx      (pick_idx)
  );

  txmb_seq #(.IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .found    (found),
    .pick_idx (pick_idx),
    .eng_done (eng_done),
    .eng_lost (eng_lost),
    .eng_err  (eng_err),
    .busy     (busy),
    .cur_idx  (cur_idx),
    .launch   (launch),
    .end_ok   (end_ok),
    .end_fail (end_fail)
  );

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic on_wire;
    logic flight;

    // on_wire: owns the current frame; flight also covers the launch edge
    assign on_wire = busy && (cur_idx == IW'(g));
    assign flight  = on_wire || (launch && (pick_idx == IW'(g)));

    txmb_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_en && (wr_mb == IW'(g))),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .kill_port (abort_en && abort_mask[g]),
      .in_flight (flight),
      .end_ok    (end_ok && on_wire),
      .end_fail  (end_fail && on_wire),
      .eligible  (elig[g]),
      .prio      (prio[g]),
      .frame     (frames[g]),
      .ready     (mb_ready[g]),
      .aborted   (mb_aborted[g]),
      .event_o   (mb_event[g])
    );
  end

  assign cur_frame = frames[cur_idx];
  assign eng_req   = busy;
  assign eng_mb    = cur_idx;
  assign eng_ide   = cur_frame.ide;
  assign eng_base  = cur_frame.base;
  assign eng_xid   = cur_frame.xid;
  assign eng_dlc   = cur_frame.dlc;
  assign eng_rtr   = cur_frame.rtr;
  assign eng_data  = cur_frame.data;

endmodule

// File: rtl/txmb_checker.sv
module txmb_checker #(
  parameter int NUM_MB = 8,
  parameter int IW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_req,
  input logic [IW-1:0]     eng_mb,
  input logic              eng_done,
  input logic              eng_lost,
  input logic              eng_err,
  input logic [NUM_MB-1:0] mb_ready,
  input logic [NUM_MB-1:0] mb_aborted,
  input logic [NUM_MB-1:0] mb_event
);

  assert_pick_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_req) |-> !mb_ready[eng_mb] && !mb_aborted[eng_mb]);

  assert_hold_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !(eng_done || eng_lost || eng_err)) |=> (eng_req && $stable(eng_mb)));

  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done) |=> (mb_ready[$past(eng_mb)] && mb_event[$past(eng_mb)]));

  assert_retry_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done && (eng_lost || eng_err)) |=> !mb_ready[$past(eng_mb)]);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_ready & mb_aborted) == '0);

endmodule

bind txmb_arbiter txmb_checker #(.NUM_MB(NUM_MB), .IW(IW)) u_txmb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_req    (eng_req),
  .eng_mb     (eng_mb),
  .eng_done   (eng_done),
  .eng_lost   (eng_lost),
  .eng_err    (eng_err),
  .mb_ready   (mb_ready),
  .mb_aborted (mb_aborted),
  .mb_event   (mb_event)
);

// File: tb/test_txmb_arbiter.sv
module test_txmb_arbiter;
  import txmb_pkg::*;

  localparam int NMB = 8;
  localparam int MW  = 3;

  typedef struct packed {
    logic [MW-1:0] mb;
    logic          ide;
    logic [10:0]   base;
    logic [17:0]   xid;
    logic [3:0]    dlc;
    logic          rtr;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [MW-1:0]  wr_mb = '0;
  logic [2:0]     wr_sel = '0;
  logic [31:0]    wr_data = '0;
  logic           abort_en = 1'b0;
  logic [NMB-1:0] abort_mask = '0;
  logic           eng_req;
  logic [MW-1:0]  eng_mb;
  logic           eng_ide;
  logic [10:0]    eng_base;
  logic [17:0]    eng_xid;
  logic [3:0]     eng_dlc;
  logic           eng_rtr;
  logic [63:0]    eng_data;
  logic           eng_done = 1'b0;
  logic           eng_lost = 1'b0;
  logic           eng_err = 1'b0;
  logic [NMB-1:0] mb_ready;
  logic [NMB-1:0] mb_aborted;
  logic [NMB-1:0] mb_event;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done_flag = 1'b0;
  exp_t sb_q[$];
  logic prev_req = 1'b0;

  always #10 clk = ~clk;

  txmb_arbiter #(.NUM_MB(NMB)) i_txmb_arbiter (
    .clk, .rst_n, .wr_en, .wr_mb, .wr_sel, .wr_data, .abort_en, .abort_mask,
    .eng_req, .eng_mb, .eng_ide, .eng_base, .eng_xid, .eng_dlc, .eng_rtr,
    .eng_data, .eng_done, .eng_lost, .eng_err, .mb_ready, .mb_aborted, .mb_event
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] data_for(input int mb);
    return {32'hABCD_0000 + 32'(mb), 32'h1111_0000 + 32'(mb)};
  endfunction

  // monitor: pops the scoreboard on each new request
  always @(negedge clk) begin
    if (rst_n) begin
      if (eng_req && !prev_req) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5 unexpected request", 64'(eng_mb), 64'hFF);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(eng_mb == e.mb, "R3 R4 mailbox order", 64'(eng_mb), 64'(e.mb));
          chk({eng_ide, eng_base, eng_xid, eng_dlc, eng_rtr} ==
              {e.ide, e.base, e.xid, e.dlc, e.rtr}, "R2 frame fields",
              64'({eng_ide, eng_base, eng_xid, eng_dlc, eng_rtr}),
              64'({e.ide, e.base, e.xid, e.dlc, e.rtr}));
          chk(eng_data == data_for(int'(e.mb)), "R2 frame data", eng_data,
              data_for(int'(e.mb)));
        end
      end
      prev_req = eng_req;
    end
  end

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    summary();
  end

  // all driver tasks start and end at posedge + 1
  task automatic wr(input int mb, input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_mb = MW'(mb); wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic setup(input int mb, input int pr, input logic [10:0] base);
    wr(mb, SEL_MODE, 32'h0);
    wr(mb, SEL_IDENT, {3'b000, base, 18'h0});
    wr(mb, SEL_DLO, data_for(mb)[31:0]);
    wr(mb, SEL_DHI, data_for(mb)[63:32]);
    wr(mb, SEL_MODE, (32'd3 << 24) | (32'(pr) << 16));
  endtask

  task automatic push(input int mb, input logic ide, input logic [10:0] base,
                      input logic [17:0] xid, input logic [3:0] dlc, input logic rtr);
    sb_q.push_back({MW'(mb), ide, base, xid, dlc, rtr});
  endtask

  task automatic arm(input int mb, input logic [3:0] dlc, input logic rtr);
    wr(mb, SEL_CTRL, (32'd1 << 23) | (32'(rtr) << 20) | (32'(dlc) << 16));
  endtask

  task automatic abort(input logic [NMB-1:0] m);
    abort_en = 1'b1; abort_mask = m;
    @(posedge clk); #1;
    abort_en = 1'b0; abort_mask = '0;
  endtask

  task automatic wait_req;
    while (!eng_req) begin @(posedge clk); #1; end
  endtask

  // kind: 0 done, 1 lost, 2 error
  task automatic respond(input int kind);
    wait_req();
    eng_done = (kind == 0); eng_lost = (kind == 1); eng_err = (kind == 2);
    @(posedge clk); #1;
    eng_done = 1'b0; eng_lost = 1'b0; eng_err = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic blocker;
    setup(0, 15, 11'h7F0);
    push(0, 1'b0, 11'h7F0, 18'h0, 4'd1, 1'b0);
    arm(0, 4'd1, 1'b0);
    wait_req();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(mb_ready == '1, "R1 ready after reset", 64'(mb_ready), 64'hFF);
    chk(mb_aborted == '0, "R1 aborted after reset", 64'(mb_aborted), 64'h0);
    chk(!eng_req && mb_event == '0, "R1 no request or event", 64'({eng_req, mb_event}), 64'h0);

    // R2 / R6 single frame
    setup(2, 5, 11'h123);
    push(2, 1'b0, 11'h123, 18'h0, 4'd4, 1'b0);
    arm(2, 4'd4, 1'b0);
    chk(!mb_ready[2], "R2 ready cleared on arm", 64'(mb_ready[2]), 64'h0);
    @(posedge clk); #1;
    chk(eng_req && eng_mb == 3'd2, "R2 request two edges after arm",
        64'({eng_req, eng_mb}), 64'h0A);
    respond(0);
    chk(mb_ready[2] && mb_event[2], "R6 ready and event after done",
        64'({mb_ready[2], mb_event[2]}), 64'h3);
    @(posedge clk); #1;
    chk(!mb_event[2], "R6 event lasts one cycle", 64'(mb_event[2]), 64'h0);

    // R3 / R5 priority behind a long frame
    blocker();
    setup(1, 9, 11'h101);
    setup(5, 2, 11'h105);
    setup(6, 7, 11'h106);
    push(5, 1'b0, 11'h105, 18'h0, 4'd2, 1'b0);
    push(6, 1'b0, 11'h106, 18'h0, 4'd3, 1'b0);
    push(1, 1'b0, 11'h101, 18'h0, 4'd1, 1'b0);
    arm(1, 4'd1, 1'b0);
    arm(5, 4'd2, 1'b0);
    arm(6, 4'd3, 1'b0);
    idle(2);
    chk(eng_req && eng_mb == 3'd0, "R5 no pre-emption of frame on wire",
        64'(eng_mb), 64'h0);
    respond(0);
    respond(0);
    respond(0);
    respond(0);

    // R4 equal priority, armed in descending order
    blocker();
    setup(7, 4, 11'h207);
    setup(4, 4, 11'h204);
    setup(3, 4, 11'h203);
    push(3, 1'b0, 11'h203, 18'h0, 4'd5, 1'b0);
    push(4, 1'b0, 11'h204, 18'h0, 4'd6, 1'b0);
    push(7, 1'b0, 11'h207, 18'h0, 4'd7, 1'b0);
    arm(7, 4'd7, 1'b0);
    arm(4, 4'd6, 1'b0);
    arm(3, 4'd5, 1'b0);
    repeat (4) respond(0);

    // R7 lost and error keep the mailbox pending
    setup(2, 3, 11'h0F2);
    repeat (3) push(2, 1'b0, 11'h0F2, 18'h0, 4'd8, 1'b0);
    arm(2, 4'd8, 1'b0);
    respond(1);
    chk(!mb_ready[2] && !mb_aborted[2], "R7 pending after lost",
        64'({mb_ready[2], mb_aborted[2]}), 64'h0);
    respond(2);
    chk(!mb_ready[2], "R7 pending after error", 64'(mb_ready[2]), 64'h0);
    respond(0);
    chk(mb_ready[2], "R7 ready after final success", 64'(mb_ready[2]), 64'h1);

    // R8 abort of waiting mailboxes
    blocker();
    setup(3, 1, 11'h303);
    setup(4, 1, 11'h304);
    push(4, 1'b0, 11'h304, 18'h0, 4'd2, 1'b0);
    arm(3, 4'd2, 1'b0);
    arm(4, 4'd2, 1'b0);
    abort(8'b0000_1000 | 8'b1000_0000);
    chk(mb_aborted[3] && mb_event[3] && !mb_ready[3], "R8 waiting mailbox aborted",
        64'({mb_aborted[3], mb_event[3], mb_ready[3]}), 64'h6);
    chk(mb_ready[7] && !mb_aborted[7] && !mb_event[7], "R8 idle mailbox unaffected",
        64'({mb_ready[7], mb_aborted[7], mb_event[7]}), 64'h4);
    respond(0);
    respond(0);
    idle(3);
    chk(!eng_req && mb_aborted[3], "R8 aborted mailbox never sent",
        64'({eng_req, mb_aborted[3]}), 64'h1);

    // R9 deferred abort of the frame on the wire, failing ending
    setup(5, 0, 11'h405);
    push(5, 1'b0, 11'h405, 18'h0, 4'd3, 1'b0);
    arm(5, 4'd3, 1'b0);
    wait_req();
    abort(8'b0010_0000);
    chk(eng_req && !mb_aborted[5], "R9 abort on wire deferred",
        64'({eng_req, mb_aborted[5]}), 64'h2);
    respond(1);
    chk(mb_aborted[5] && mb_event[5] && !mb_ready[5], "R9 aborted after lost",
        64'({mb_aborted[5], mb_event[5], mb_ready[5]}), 64'h6);
    idle(4);
    chk(!eng_req, "R9 no retry after deferred abort", 64'(eng_req), 64'h0);

    // R9 deferred abort, successful ending
    push(5, 1'b0, 11'h405, 18'h0, 4'd3, 1'b0);
    arm(5, 4'd3, 1'b0);
    chk(!mb_aborted[5], "R2 arm clears aborted", 64'(mb_aborted[5]), 64'h0);
    wait_req();
    abort(8'b0010_0000);
    respond(0);
    chk(mb_ready[5] && !mb_aborted[5], "R9 success wins over deferred abort",
        64'({mb_ready[5], mb_aborted[5]}), 64'h2);

    // R12 abort through the control word
    blocker();
    setup(6, 2, 11'h506);
    arm(6, 4'd1, 1'b0);
    wr(6, SEL_CTRL, 32'd1 << 22);
    chk(mb_aborted[6] && mb_event[6], "R12 control cancel",
        64'({mb_aborted[6], mb_event[6]}), 64'h3);
    respond(0);
    idle(3);
    chk(!eng_req, "R12 cancelled mailbox not sent", 64'(eng_req), 64'h0);

    // R10 identifier write only while disabled
    setup(1, 2, 11'h0AA);
    wr(1, SEL_IDENT, {3'b001, 11'h555, 18'h3FFFF});
    push(1, 1'b0, 11'h0AA, 18'h0, 4'd8, 1'b0);
    arm(1, 4'd8, 1'b0);
    respond(0);
    wr(1, SEL_MODE, 32'h0);
    wr(1, SEL_IDENT, {3'b001, 11'h2A5, 18'h3C3C3});
    wr(1, SEL_MODE, (32'd3 << 24) | (32'd2 << 16));
    push(1, 1'b1, 11'h2A5, 18'h3C3C3, 4'd2, 1'b1);
    arm(1, 4'd2, 1'b1);
    respond(0);

    // R11 arm of a disabled mailbox
    wr(7, SEL_MODE, 32'h0);
    arm(7, 4'd1, 1'b0);
    idle(3);
    chk(!eng_req && mb_ready[7], "R11 disabled mailbox ignores arm",
        64'({eng_req, mb_ready[7]}), 64'h1);

    idle(5);
    chk(sb_q.size() == 0, "R7 all expected frames seen", 64'(sb_q.size()), 64'h0);
    summary();
  end

endmodule